// File: doc/BRIEF.md
# Two-Step Status Flag Clear Controller

This block holds the sticky status flags of a serial port. Each flag is set by a one-cycle hardware event pulse and stays set until software clears it or a DMA engine acknowledges it. Software clears a flag in two steps. It first reads the status register, which arms every flag that is set at that moment. It then accesses the data register, and that access clears the armed flags of matching type. Transmit-side flags need a data write. Receive-side flags need a data read. Other bus traffic may come between the two steps, but the status read must come first.

Each flag has a DMA-enable bit. A set flag whose DMA-enable bit is high raises the DMA request, and a DMA-done strobe clears it. A set flag whose DMA-enable bit is low raises the interrupt request. The transmit and receive datapaths are not part of this block. Event pulses stand in for them.

Top module: `uart_flagclr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `flags` is all zero and `irq` and `dma_req` are low.
- R2: A high bit in `evt_set` during a clock cycle sets the matching bit of `flags` from the next cycle on.
- R3: A receive-side flag (bit i with `TX_MASK[i]` = 0; by default bits 2 and 3) that was set when the status register was read clears in the cycle after a later data-register read. A data-register write leaves it set.
- R4: A transmit-side flag (bit i with `TX_MASK[i]` = 1; by default bits 0 and 1) that was set when the status register was read clears in the cycle after a later data-register write. A data-register read leaves it set.
- R5: A data-register access clears no flag unless a status-register read came before it and no data access of the matching kind has since used up that arming.
- R6: Idle cycles and data accesses of the other kind between the status read and the clearing access do not cancel the arming.
- R7: A flag that was 0 at the status read, and is set afterwards, is not cleared by the following data access.
- R8: When a set event and a clear (software or DMA) act on the same flag in the same cycle, the flag stays set.
- R9: A `dma_done` strobe clears every set flag whose `dma_en` bit is high and leaves flags whose `dma_en` bit is low unchanged.
- R10: `irq` is high exactly when some set flag has `dma_en` low. `dma_req` is high exactly when some set flag has `dma_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_is_data | input | 1 | Address select: 1 = data register, 0 = status register |
| evt_set | input | N_FLAGS | Hardware event pulses, one per flag |
| dma_en | input | N_FLAGS | Per-flag DMA enable |
| dma_done | input | 1 | DMA completion strobe |
| flags | output | N_FLAGS | Current flag values (status register contents) |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Several rules are checked on every cycle. Each event sets its flag. Flags never drop during a cycle with no bus access and no DMA strobe. A DMA strobe leaves no DMA-enabled flag set unless an event set it again in the same cycle. The request outputs always match the flags that are set and their DMA-enable bits. Reset leaves everything at zero. Other behaviour depends on a history of several bus accesses, so only the bench's directed scenarios show it. This covers the difference between transmit-side and receive-side flags, arming only the flags that were set at the status read, arming that survives unrelated traffic and is used up after one clear, and the set-wins race.

// File: rtl/uart_flagclr_pkg.sv
package uart_flagclr_pkg;

    // Decoded bus command for one cycle
    typedef struct packed {
        logic status_rd;
        logic data_rd;
        logic data_wr;
    } bus_cmd_t;

    // Per-flag state: the flag itself and its clear-arming bit
    typedef struct packed {
        logic flag;
        logic arm;
    } flag_state_t;

endpackage

// File: rtl/uart_flagclr_decode.sv
module uart_flagclr_decode
    import uart_flagclr_pkg::*;
(
    input  logic     bus_rd,
    input  logic     bus_wr,
    input  logic     bus_is_data,
    output bus_cmd_t cmd
);

    always_comb begin
        cmd           = '0;
        cmd.status_rd = bus_rd & ~bus_is_data;
        cmd.data_rd   = bus_rd &  bus_is_data;
        cmd.data_wr   = bus_wr &  bus_is_data;
    end

endmodule

// File: rtl/uart_flagclr_slice.sv
module uart_flagclr_slice
    import uart_flagclr_pkg::*;
#(
    parameter bit IS_TX = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_cmd_t cmd,
    input  logic     evt,
    input  logic     dma_en,
    input  logic     dma_done,
    output logic     flag
);

    flag_state_t st_d, st_q;
    logic        sw_hit;
    logic        clr_sw;
    logic        clr_dma;

    always_comb begin
        // Second step: access kind depends on the flag side
        sw_hit  = IS_TX ? cmd.data_wr : cmd.data_rd;
        clr_sw  = st_q.arm & sw_hit;
        clr_dma = dma_done & dma_en & st_q.flag;

        st_d = st_q;
        // Set event wins over any clear in the same cycle
        st_d.flag = evt | (st_q.flag & ~clr_sw & ~clr_dma);
        if (cmd.status_rd) begin
            // Arm only what is set at the moment of the read
            st_d.arm = st_q.flag;
        end else begin
            st_d.arm = st_q.arm & ~clr_sw & ~clr_dma;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/uart_flagclr_reqs.sv
module uart_flagclr_reqs #(
    parameter int N_FLAGS = 4
) (
    input  logic [N_FLAGS-1:0] flags,
    input  logic [N_FLAGS-1:0] dma_en,
    output logic               irq,
    output logic               dma_req
);

    always_comb begin
        irq     = |(flags & ~dma_en);
        dma_req = |(flags &  dma_en);
    end

endmodule

// File: rtl/uart_flagclr.sv
module uart_flagclr
    import uart_flagclr_pkg::*;
#(
    parameter int                N_FLAGS = 4,
    parameter logic [N_FLAGS-1:0] TX_MASK = 4'b0011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_is_data,
    input  logic [N_FLAGS-1:0] evt_set,
    input  logic [N_FLAGS-1:0] dma_en,
    input  logic               dma_done,
    output logic [N_FLAGS-1:0] flags,
    output logic               irq,
    output logic               dma_req
);

    bus_cmd_t cmd;

    uart_flagclr_decode u_decode (
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_is_data (bus_is_data),
        .cmd         (cmd)
    );

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        uart_flagclr_slice #(
            .IS_TX (TX_MASK[i])
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .evt      (evt_set[i]),
            .dma_en   (dma_en[i]),
            .dma_done (dma_done),
            .flag     (flags[i])
        );
    end

    uart_flagclr_reqs #(
        .N_FLAGS (N_FLAGS)
    ) u_reqs (
        .flags   (flags),
        .dma_en  (dma_en),
        .irq     (irq),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/uart_flagclr_chk.sv
module uart_flagclr_chk #(
    parameter int N_FLAGS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [N_FLAGS-1:0] evt_set,
    input logic [N_FLAGS-1:0] dma_en,
    input logic               dma_done,
    input logic [N_FLAGS-1:0] flags,
    input logic               irq,
    input logic               dma_req
);

    // R1: reset leaves all flags clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

    // R2: an event pulse sets its flag one cycle later
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set)));

    // R5: with no bus access and no DMA strobe no flag drops
    a_r5_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr && !dma_done) |=> ((flags & $past(flags)) == $past(flags)));

    // R9: DMA strobe clears the DMA-enabled flags unless re-set in that cycle
    a_r9_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> ((flags & $past(flags & dma_en & ~evt_set)) == '0));

    // R10: request outputs follow the set flags and their DMA enables
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(flags & ~dma_en)));
    a_r10_dma_source: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req == (|(flags & dma_en)));

endmodule

bind uart_flagclr uart_flagclr_chk #(.N_FLAGS(N_FLAGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .evt_set  (evt_set),
    .dma_en   (dma_en),
    .dma_done (dma_done),
    .flags    (flags),
    .irq      (irq),
    .dma_req  (dma_req)
);

// File: tb/uart_flagclr_bench.sv
module uart_flagclr_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_is_data = 1'b0;
    logic [N-1:0] evt_set = '0;
    logic [N-1:0] dma_en = '0;
    logic         dma_done = 1'b0;
    logic [N-1:0] flags;
    logic         irq;
    logic         dma_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_flagclr u_uart_flagclr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_is_data (bus_is_data),
        .evt_set     (evt_set),
        .dma_en      (dma_en),
        .dma_done    (dma_done),
        .flags       (flags),
        .irq         (irq),
        .dma_req     (dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle strobe; returns at the negedge after the active edge
    task automatic bus_op(input bit rd, input bit wr, input bit is_data, input logic [N-1:0] evt);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_is_data = is_data; evt_set = evt;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_is_data = 1'b0; evt_set = '0;
    endtask

    task automatic pulse_evt(input logic [N-1:0] m);
        bus_op(1'b0, 1'b0, 1'b0, m);
    endtask
    task automatic stat_rd();
        bus_op(1'b1, 1'b0, 1'b0, '0);
    endtask
    task automatic data_rd();
        bus_op(1'b1, 1'b0, 1'b1, '0);
    endtask
    task automatic data_wr();
        bus_op(1'b0, 1'b1, 1'b1, '0);
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 flags in reset", flags, 0);
        check("R1 irq in reset", irq, 0);
        check("R1 dma_req in reset", dma_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", flags, 0);
    endtask

    task automatic t_set_and_rx_clear();
        pulse_evt(4'b0100);
        check("R2 event sets flag", flags, 4'b0100);
        check("R10 irq from non-dma flag", irq, 1);
        check("R10 dma_req low", dma_req, 0);
        stat_rd();
        data_wr();
        check("R3 write keeps rx flag", flags, 4'b0100);
        data_rd();
        check("R3 data read clears rx flag", flags, 0);
        check("R10 irq drops", irq, 0);
    endtask

    task automatic t_tx_clear();
        pulse_evt(4'b0001);
        stat_rd();
        data_rd();
        check("R4 read keeps tx flag", flags, 4'b0001);
        data_wr();
        check("R4 data write clears tx flag", flags, 0);
    endtask

    task automatic t_no_arm_and_gap();
        pulse_evt(4'b0100);
        data_rd();
        check("R5 data read without status read", flags, 4'b0100);
        stat_rd();
        idle(3);
        data_wr();
        check("R6 gap and other access keep arming", flags, 4'b0100);
        data_rd();
        check("R6 clear after gap", flags, 0);
    endtask

    task automatic t_late_set();
        stat_rd();
        pulse_evt(4'b1000);
        data_rd();
        check("R7 late flag not cleared", flags, 4'b1000);
        stat_rd();
        data_rd();
        check("R7 cleared after fresh status read", flags, 0);
    endtask

    task automatic t_race();
        pulse_evt(4'b0100);
        stat_rd();
        bus_op(1'b1, 1'b0, 1'b1, 4'b0100);
        check("R8 set wins over clear", flags, 4'b0100);
        data_rd();
        check("R5 arming used up", flags, 4'b0100);
        stat_rd();
        data_rd();
        check("R3 cleanup", flags, 0);
    endtask

    task automatic t_dma();
        dma_en = 4'b0110;
        pulse_evt(4'b0111);
        check("R10 irq with mixed flags", irq, 1);
        check("R10 dma_req with mixed flags", dma_req, 1);
        @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        check("R9 dma clears only enabled flags", flags, 4'b0001);
        check("R10 dma_req drops", dma_req, 0);
        dma_en = '0;
        stat_rd();
        data_wr();
        check("R4 cleanup", flags, 0);
    endtask

    initial begin
        t_reset();
        t_set_and_rx_clear();
        t_tx_clear();
        t_no_arm_and_gap();
        t_late_set();
        t_race();
        t_dma();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule